// File: doc/BRIEF.md
# SHA-512 Message Schedule Partial-Sum Unit

This block performs the first half of the SHA-512 message-schedule expansion for four 64-bit message words in one step. It takes a 256-bit operand holding four consecutive schedule words and a 128-bit operand whose low 64-bit lane holds the word that follows them. Every output lane is the word in that lane plus the small sigma-zero mixing of the word one position above it. The top lane takes its upper neighbour from the second operand.

The later steps of the schedule are done elsewhere: adding the sigma-one term and the word seven positions back. Operands enter through a valid/ready handshake. The result is captured in a single output register and is offered through a matching valid/ready handshake. An operand pair can be accepted in the same cycle as the previous result leaves, so the unit sustains one result per clock.

Top module: `sha512_sched_pre`

## Requirements
- R1: Output lane i (bits 64*i+63 down to 64*i, i = 0..3) equals word i of `in_words` plus sigma0 of word i+1. The window holds five words: words 0..3 are lanes 0..3 of `in_words`, and word 4 is bits 63:0 of `in_next`.
- R2: sigma0(x) is the XOR of three terms: x rotated right by 1, x rotated right by 8, and x shifted right by 7 with zero fill.
- R3: Each lane sum is taken modulo 2^64, and no carry passes between lanes.
- R4: Output lane 3 uses bits 63:0 of `in_next` as its neighbour. Bits 127:64 of `in_next` have no effect on the result.
- R5: An operand pair is accepted only in a cycle where `in_valid` and `in_ready` are both high. `out_valid` is high in the cycle after the acceptance, and `out_words` then holds the result for that pair.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_words` and `out_valid` hold their values.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_words` to zero.
- R8: When the result is consumed (`out_valid` and `out_ready` both high) and no new pair is accepted, `out_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_words | input | 256 | Four schedule words, lane 0 in bits 63:0 |
| in_next | input | 128 | Low lane holds the word after lane 3; high lane unused |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result |
| out_words | output | 256 | Four partial schedule words |

## Verification
Several kinds of input are applied. Random words exercise all three sigma terms together. Single-bit words in chosen lanes separate the rotate terms from the shift term and show which neighbour each lane draws from. All-ones words force a wrap-around in every lane, which exposes a sum that is too wide or a carry that leaks into the next lane. Pairs that differ only in the high lane of `in_next` must give identical results. A held stall with a different operand pending shows whether the register is overwritten. Dropping `out_ready` tells apart a correct stall from the case where data is lost or taken twice.

// File: rtl/sha512_sched_pre.sv
module sha512_sched_pre #(
  parameter int WORD    = 64,
  parameter int LANES   = 4,
  parameter int ROT_A   = 1,
  parameter int ROT_B   = 8,
  parameter int SHIFT_C = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WORD*LANES-1:0]  in_words,
  input  logic [2*WORD-1:0]      in_next,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORD*LANES-1:0]  out_words
);
  localparam int VEC = WORD * LANES;

  function automatic logic [WORD-1:0] sig0(input logic [WORD-1:0] x);
    return ((x >> ROT_A) | (x << (WORD - ROT_A))) ^
           ((x >> ROT_B) | (x << (WORD - ROT_B))) ^
           (x >> SHIFT_C);
  endfunction

  logic [VEC-1:0] sum;
  logic           take;
  logic           unused_hi;

  assign unused_hi = ^in_next[2*WORD-1:WORD];
  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD-1:0] upper;
    if (i == LANES - 1) begin : g_top
      assign upper = in_next[WORD-1:0];
    end else begin : g_mid
      assign upper = in_words[(i+1)*WORD +: WORD];
    end
    assign sum[i*WORD +: WORD] = in_words[i*WORD +: WORD] + sig0(upper);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_words <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_words <= sum;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module sha512_sched_pre_chk #(
  parameter int WORD  = 64,
  parameter int LANES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WORD*LANES-1:0] out_words
);
  p_accept_then_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_stall_blocks_input_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_holds_data_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_words)));

  p_drain_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_idle_ready_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind sha512_sched_pre sha512_sched_pre_chk #(.WORD(WORD), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_words(out_words)
);

// File: tb/sim_sha512_sched_pre.sv
`timescale 1ns/1ps
module sim_sha512_sched_pre;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [255:0] in_words;
  logic [127:0] in_next;
  logic         out_valid;
  logic         out_ready;
  logic [255:0] out_words;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sha512_sched_pre u0 (.*);

  function automatic logic [63:0] ror(input logic [63:0] x, input int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  function automatic logic [63:0] s0_ref(input logic [63:0] x);
    return ror(x, 1) ^ ror(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [255:0] model(input logic [255:0] a, input logic [127:0] b);
    logic [63:0] w [5];
    logic [255:0] r;
    for (int k = 0; k < 4; k++) w[k] = a[64*k +: 64];
    w[4] = b[63:0];
    for (int k = 0; k < 4; k++) r[64*k +: 64] = w[k] + s0_ref(w[k+1]);
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, sample at following negedge
  task automatic send(input string req, input logic [255:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_words = a; in_next = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {255'd0, out_valid}, 256'd1);
    check(req, out_words, model(a, b));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] xa, ya, held;
    logic [127:0] xb, yb;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_words = '1; in_next = '1;
    repeat (3) @(negedge clk);
    check("R7 reset valid", {255'd0, out_valid}, 256'd0);
    check("R7 reset data", out_words, 256'd0);
    check("R6 ready idle", {255'd0, in_ready}, 256'd1);
    rst = 1'b0;

    // R2: single bits in the top neighbour isolate the sigma terms
    send("R2 bit0", 256'd0, {64'd0, 64'h1});
    send("R2 bit7", 256'd0, {64'd0, 64'h80});
    send("R2 bit63", 256'd0, {64'd0, 64'h8000_0000_0000_0000});
    // R1: neighbour selection per lane
    send("R1 lane1src", {64'd0, 64'd0, 64'h100, 64'd0}, 128'd0);
    send("R1 lane3src", {64'h0000_0001_0000_0000, 64'd0, 64'd0, 64'd0}, 128'd0);
    // R3: wrap-around in every lane, no inter-lane carry
    send("R3 wrap", '1, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    send("R3 wrap2", {4{64'hFFFF_FFFF_FFFF_FFF0}}, {64'd0, 64'h0000_0000_0000_0100});
    // R4: high lane of in_next ignored
    xa = {rnd64(), rnd64(), rnd64(), rnd64()};
    send("R4 hi0", xa, {64'd0, 64'h1234_5678_9ABC_DEF0});
    send("R4 hiX", xa, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0});
    check("R4 same", out_words, model(xa, {64'd0, 64'h1234_5678_9ABC_DEF0}));

    // R6: stall
    xa = {rnd64(), rnd64(), rnd64(), rnd64()}; xb = {rnd64(), rnd64()};
    ya = {rnd64(), rnd64(), rnd64(), rnd64()}; yb = {rnd64(), rnd64()};
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_words = xa; in_next = xb;
    @(negedge clk);
    in_words = ya; in_next = yb;
    check("R5 valid after accept", {255'd0, out_valid}, 256'd1);
    check("R6 ready low in stall", {255'd0, in_ready}, 256'd0);
    held = out_words;
    check("R5 data", held, model(xa, xb));
    repeat (4) @(negedge clk);
    check("R6 held data", out_words, model(xa, xb));
    check("R6 held valid", {255'd0, out_valid}, 256'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 back-to-back", out_words, model(ya, yb));
    @(negedge clk);
    check("R8 drained", {255'd0, out_valid}, 256'd0);

    // R5: in_valid low is not accepted
    in_words = xa; in_next = xb;
    repeat (2) @(negedge clk);
    check("R5 no accept", {255'd0, out_valid}, 256'd0);

    // R7: reset while holding a result
    send("R1 pre-reset", xa, xb);
    out_ready = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R7 mid reset valid", {255'd0, out_valid}, 256'd0);
    check("R7 mid reset data", out_words, 256'd0);
    out_ready = 1'b1;

    // R1 random with random stalls
    for (int n = 0; n < 300; n++) begin
      xa = {rnd64(), rnd64(), rnd64(), rnd64()}; xb = {rnd64(), rnd64()};
      send("R1 random", xa, xb);
      if (($urandom() & 3) == 0) begin
        out_ready = 1'b0;
        @(negedge clk);
        check("R6 random hold", out_words, model(xa, xb));
        out_ready = 1'b1;
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule